// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block counts scanline events and raises an interrupt to the CPU once a programmed number of lines has gone by. The CPU programs it through four write decodes in the upper quarter of its address space. The decodes store a reload value, request a reload on the next scanline event, disarm and acknowledge the interrupt, and arm it. A separate one-cycle pulse per scanline drives the counter. This block does not generate that pulse.

On each scanline event the counter either takes the stored reload value or counts down by one. It takes the reload value when it is already zero or when a reload request is outstanding. The interrupt is raised when the counter lands on zero while the block is armed. The line then stays high until the CPU acknowledges it. A build parameter picks between two variants. The default variant fires on every zero, including a zero produced by a reload. The strict variant fires only when the counter held a nonzero value before the event.

Top module: `line_irq_timer`

## Requirements
- R1: A write whose address has bits [15:13] = 3'b110 and bit 0 = 0 stores wrData as the reload value. That value is used by the next reload.
- R2: A write whose address has bits [15:13] = 3'b110 and bit 0 = 1 sets a pending-reload flag. It does not change the counter.
- R3: A write whose address has bits [15:13] = 3'b111 and bit 0 = 0 disarms the block. It also drops irqOut from the next cycle on.
- R4: A write whose address has bits [15:13] = 3'b111 and bit 0 = 1 arms the block. It does not clear an irqOut that is already high.
- R5: On a lineTick cycle the counter loads the reload value and clears the pending flag if the counter is zero or a reload is pending. Otherwise it decrements by one. Without lineTick the counter holds.
- R6: If a lineTick cycle leaves the counter at zero and the block was armed before that cycle, irqOut is high from the next cycle on. It stays high until a disarm write.
- R7: With STRICT_REV = 1, the R6 condition also needs the counter to have been nonzero before the lineTick cycle.
- R8: With the default variant and a reload value of 0, every lineTick fires while the block is armed.
- R9: A reload-request write in the same cycle as lineTick counts as pending for that event. The flag is left clear afterwards.
- R10: Writes whose address bits [15:14] are not 2'b11 change nothing.
- R11: After reset the counter, the reload value, the pending flag, the arm bit and irqOut are all zero.
- R12: A disarm write in the same cycle as a firing lineTick wins, so irqOut stays low. A reload-value write in the same cycle as lineTick takes effect only for later reloads. An arm write in the same cycle as lineTick does not enable that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | CPU write strobe, one cycle per write |
| wrAddr | input | 16 | CPU write address |
| wrData | input | 8 | CPU write data |
| lineTick | input | 1 | One-cycle pulse per scanline |
| irqOut | output | 1 | Level interrupt request, active high |

## Verification
A wrong counter value or a lost pending flag shows at the ports as an interrupt that comes one or more scanline events early or late. A stale arm bit shows as an interrupt that appears or fails to appear on the event that reaches zero. A broken acknowledge path leaves irqOut high in the cycle after the disarm write. The bench runs a bench-side model of every state bit and compares irqOut on every cycle, on both the default and the strict instance. Any divergence is therefore reported at the first scanline event where it matters, or in the cycle right after the offending write.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;
  // One-cycle strobes from the write decoder to the counter datapath.
  typedef struct packed {
    logic latchWr;
    logic reloadReq;
    logic enClr;
    logic enSet;
  } irqStrobes_t;
endpackage

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
  import line_irq_pkg::*;
(
  input  logic        wrEn,
  input  logic [2:0]  addrTop,
  input  logic        addrLsb,
  output irqStrobes_t stb
);
  logic latchPage;
  logic armPage;

  // 3'b110: reload-value page, 3'b111: arm/acknowledge page
  assign latchPage = wrEn && (addrTop == 3'b110);
  assign armPage   = wrEn && (addrTop == 3'b111);

  always_comb begin
    stb           = '0;
    stb.latchWr   = latchPage && !addrLsb;
    stb.reloadReq = latchPage &&  addrLsb;
    stb.enClr     = armPage   && !addrLsb;
    stb.enSet     = armPage   &&  addrLsb;
  end
endmodule

// File: rtl/line_irq_dp.sv
module line_irq_dp
  import line_irq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter bit STRICT_REV = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  irqStrobes_t      stb,
  input  logic [CNT_W-1:0] wrData,
  input  logic             lineTick,
  output logic             irqOut,
  output logic [CNT_W-1:0] cntOut
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] latchQ;
  logic             relQ;
  logic             enQ;
  logic             irqQ;

  logic             relEff;
  logic             reloadNow;
  logic [CNT_W-1:0] cntNext;
  logic             hitZero;
  logic             fireNow;

  // a reload request in the same cycle as a tick is seen by that tick
  assign relEff    = relQ | stb.reloadReq;
  assign reloadNow = (cntQ == '0) || relEff;
  assign cntNext   = reloadNow ? latchQ : (cntQ - 1'b1);

  generate
    if (STRICT_REV) begin : g_strict
      assign hitZero = (cntNext == '0) && (cntQ != '0);
    end else begin : g_loose
      assign hitZero = (cntNext == '0);
    end
  endgenerate

  assign fireNow = lineTick && enQ && hitZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      latchQ <= '0;
      relQ   <= 1'b0;
      enQ    <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      if (lineTick) begin
        cntQ <= cntNext;
        relQ <= 1'b0;
      end else if (stb.reloadReq) begin
        relQ <= 1'b1;
      end

      if (stb.latchWr) latchQ <= wrData;

      if (stb.enClr)      enQ <= 1'b0;
      else if (stb.enSet) enQ <= 1'b1;

      if (stb.enClr)      irqQ <= 1'b0;
      else if (fireNow)   irqQ <= 1'b1;
    end
  end

  assign irqOut = irqQ;
  assign cntOut = cntQ;
endmodule

// File: rtl/line_irq_timer.sv
module line_irq_timer #(
  parameter int CNT_W      = 8,
  parameter int ADDR_W     = 16,
  parameter bit STRICT_REV = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              lineTick,
  output logic              irqOut
);
  localparam int TOP_LO = ADDR_W - 3;

  line_irq_pkg::irqStrobes_t stb;
  logic [CNT_W-1:0]          cntVal;
  logic                      unusedAddrBits;

  assign unusedAddrBits = ^wrAddr[TOP_LO-1:1];

  line_irq_ctrl u_ctrl (
    .wrEn    (wrEn),
    .addrTop (wrAddr[ADDR_W-1:TOP_LO]),
    .addrLsb (wrAddr[0]),
    .stb     (stb)
  );

  line_irq_dp #(
    .CNT_W      (CNT_W),
    .STRICT_REV (STRICT_REV)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .lineTick (lineTick),
    .irqOut   (irqOut),
    .cntOut   (cntVal)
  );
endmodule

// File: rtl/line_irq_timer_chk.sv
module line_irq_timer_chk #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              lineTick,
  input logic              irqOut,
  input logic [CNT_W-1:0]  cntVal
);
  logic ackWrite;
  assign ackWrite = wrEn && (wrAddr[ADDR_W-1:ADDR_W-3] == 3'b111) && !wrAddr[0];

  // R3: acknowledge drops the interrupt in the following cycle
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    ackWrite |=> !irqOut);

  // R6: level stays high until acknowledged
  p_irq_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !ackWrite) |=> irqOut);

  // R6: a new interrupt follows a scanline event
  p_rise_on_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(lineTick));

  // R6: a new interrupt comes with the counter at zero
  p_rise_at_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> (cntVal == '0));

  // R5: counter holds without a scanline event
  p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    !lineTick |=> (cntVal == $past(cntVal)));
endmodule

bind line_irq_timer line_irq_timer_chk #(
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .lineTick (lineTick),
  .irqOut   (irqOut),
  .cntVal   (cntVal)
);

// File: tb/line_irq_timer_tb.sv
module line_irq_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        lineTick = 1'b0;
  logic        irqLoose;
  logic        irqStrict;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state, index 0 = default variant, 1 = strict variant
  logic [7:0] mCnt [2];
  logic [7:0] mLat [2];
  logic       mRel [2];
  logic       mEn  [2];
  logic       mIrq [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  line_irq_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .lineTick(lineTick), .irqOut(irqLoose)
  );

  line_irq_timer #(.STRICT_REV(1'b1)) u_dutStrict (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .lineTick(lineTick), .irqOut(irqStrict)
  );

  function automatic void modelReset();
    for (int s = 0; s < 2; s++) begin
      mCnt[s] = '0; mLat[s] = '0; mRel[s] = 1'b0; mEn[s] = 1'b0; mIrq[s] = 1'b0;
    end
  endfunction

  function automatic void modelStep(bit w, logic [15:0] a, logic [7:0] d, bit t);
    bit pgLat = w && (a[15:13] == 3'b110);
    bit pgArm = w && (a[15:13] == 3'b111);
    for (int s = 0; s < 2; s++) begin
      logic [7:0] oldCnt = mCnt[s];
      bit rel = mRel[s] || (pgLat && a[0]);
      bit fire = 1'b0;
      if (t) begin
        if (oldCnt == 0 || rel) mCnt[s] = mLat[s];
        else mCnt[s] = oldCnt - 8'd1;
        fire = (mCnt[s] == 0) && mEn[s] && (s == 0 || oldCnt != 0);
        mRel[s] = 1'b0;
      end else begin
        mRel[s] = rel;
      end
      if (fire) mIrq[s] = 1'b1;
      if (pgLat && !a[0]) mLat[s] = d;
      if (pgArm && a[0]) mEn[s] = 1'b1;
      if (pgArm && !a[0]) begin
        mEn[s] = 1'b0;
        mIrq[s] = 1'b0;
      end
    end
  endfunction

  task automatic check(string tag);
    checks++;
    if (irqLoose !== mIrq[0]) begin
      errors++;
      $display("FAIL %s default: irqOut=%0b expected=%0b", tag, irqLoose, mIrq[0]);
    end
    checks++;
    if (irqStrict !== mIrq[1]) begin
      errors++;
      $display("FAIL R7 %s strict: irqOut=%0b expected=%0b", tag, irqStrict, mIrq[1]);
    end
  endtask

  task automatic step(bit w, logic [15:0] a, logic [7:0] d, bit t, string tag);
    wrEn = w; wrAddr = a; wrData = d; lineTick = t;
    modelStep(w, a, d, t);
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; lineTick = 1'b0;
    check(tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R11 reset");

    // R1 R2 R5 R6: reload value 3, fire on the fourth event
    step(1, 16'hC000, 8'd3, 0, "R1 latch");
    step(1, 16'hC001, 8'd0, 0, "R2 reload req");
    step(1, 16'hE001, 8'd0, 0, "R4 arm");
    step(0, 16'h0, 8'd0, 1, "R5 reload tick");
    step(0, 16'h0, 8'd0, 1, "R5 dec 2");
    step(0, 16'h0, 8'd0, 1, "R5 dec 1");
    step(0, 16'h0, 8'd0, 1, "R6 reach zero");
    step(0, 16'h0, 8'd0, 0, "R6 level held");
    step(1, 16'hE001, 8'd0, 0, "R4 rearm keeps irq");
    step(1, 16'hE000, 8'd0, 0, "R3 ack");

    // R10: writes outside the upper quarter
    step(1, 16'h8000, 8'd0, 0, "R10 ignored");
    step(1, 16'hA001, 8'd0, 0, "R10 ignored");
    step(1, 16'h6001, 8'd0, 1, "R10 ignored");
    step(1, 16'h4000, 8'd0, 1, "R10 ignored");

    // R8: reload value 0 fires on every event in the default variant
    step(1, 16'hC000, 8'd0, 0, "R8 latch0");
    step(1, 16'hE001, 8'd0, 0, "R8 arm");
    for (int i = 0; i < 3; i++) begin
      step(0, 16'h0, 8'd0, 1, "R8 tick");
      step(1, 16'hE000, 8'd0, 0, "R8 ack");
      step(1, 16'hE001, 8'd0, 0, "R8 rearm");
    end

    // R7: strict variant fires when a nonzero count reaches zero
    step(1, 16'hC000, 8'd1, 0, "R7 latch1");
    step(1, 16'hC001, 8'd0, 1, "R9 reload with tick");
    step(0, 16'h0, 8'd0, 1, "R7 one to zero");
    step(1, 16'hE000, 8'd0, 0, "R3 ack");

    // R12: ack in the same cycle as a firing event
    step(1, 16'hE001, 8'd0, 0, "R12 arm");
    step(0, 16'h0, 8'd0, 1, "R12 reload to 1");
    step(1, 16'hE000, 8'd0, 1, "R12 ack wins");
    // R12: reload-value write same cycle as event
    step(1, 16'hE001, 8'd0, 0, "R12 arm");
    step(1, 16'hC000, 8'd5, 1, "R12 latch with tick");
    step(0, 16'h0, 8'd0, 1, "R12 old latch used");
    step(1, 16'hE000, 8'd0, 0, "R12 ack");
    step(1, 16'hE001, 8'd0, 1, "R12 arm with tick");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 9);
      logic [15:0] a;
      bit w = ($urandom_range(0, 2) == 0);
      bit t = ($urandom_range(0, 9) < 4);
      case (sel)
        0: a = 16'hC000 | 16'($urandom_range(0, 16'h0FFF) << 1);
        1: a = 16'hC001;
        2: a = 16'hE000;
        3, 4: a = 16'hE001;
        5: a = 16'hC000;
        default: a = 16'($urandom_range(0, 16'hBFFF));
      endcase
      step(w, a, 8'($urandom_range(0, 7)), t, "R5 R6 random");
    end

    rstN = 1'b0;
    modelReset();
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R11 second reset");

    finishRun();
  end
endmodule